// File: doc/BRIEF.md
# Period Timer with Compare-Match Reset

This block is a 16-bit up-counter for a small microcontroller-style peripheral set. It advances on every system clock, or on rising edges of an external clock pin. External edges normally pass through a two-stage synchronizer followed by an edge detector. A control bit bypasses that synchronizer. In that case the raw pin is edge-detected directly in the system clock domain, with no added latency. When the counter rolls from 0xFFFF to 0x0000 it sets a sticky overflow flag. That flag is the block's interrupt or wake-up request.

A companion compare unit holds a 16-bit period value. When the compare mode field selects special-event operation, the counter is cleared on the advance that would take it past the period. The period value therefore sets the cycle length, which is period+1 advances. A register write to the counter overrides that clear. The clear never raises the overflow flag. The clear is suppressed while the counter runs from the unsynchronized external clock.

Software reaches the block through a byte-wide write port and a byte-wide combinational read port. Each 16-bit value is reached through two 8-bit halves. Reading both halves is therefore not atomic while the counter runs.

Top module: `period_timer`

## Requirements
- R1: On synchronous reset the count is 0x0000, the overflow flag is 0 and the period register is 0xFFFF; with mode 0, `cmp_hit` is 0.
- R2: With `en`=1 and `src_ext`=0 the count rises by one on every clock; with `en`=0 the count holds.
- R3: An advance from 0xFFFF to 0x0000 sets `ovf`. `ovf` stays set until a write to address 4 (data ignored) or reset clears it. If a set and a clear happen in the same cycle, `ovf` ends up 1.
- R4: A write to address 0 replaces count bits [7:0], and a write to address 1 replaces bits [15:8]; the other byte is kept. The count does not advance in a cycle in which it is written. Addresses 2 and 3 hold the period's low and high bytes. Reads at `rd_addr` 0 to 3 return the same bytes.
- R5: With `mode`=4'b1011, an advance that occurs while count equals period loads 0x0000 instead of count+1. This holds with the internal clock and with the synchronized external clock.
- R6: A count write in the same cycle as a special-event clear wins; the written byte is loaded.
- R7: A special-event clear never sets `ovf`, even when the period is 0xFFFF.
- R8: With `src_ext`=1 and `nosync`=1 the special-event clear is suppressed, and the count advances past the period.
- R9: `cmp_hit` is 1 exactly while `mode`=4'b1011 and count equals period, whether or not the clear is suppressed.
- R10: With `src_ext`=1 and `nosync`=0, a rising edge of `ext_clk` advances the count at the third clock edge after the rise, and it advances once per rise.
- R11: With `src_ext`=1 and `nosync`=1, a rising edge of `ext_clk` advances the count at the first clock edge after the rise, and it advances once per rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counter run enable |
| src_ext | input | 1 | 1 selects the external clock pin as the count source |
| nosync | input | 1 | 1 bypasses the external clock synchronizer |
| mode | input | 4 | Compare mode; 4'b1011 selects special-event clear |
| ext_clk | input | 1 | External count clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0/1 count bytes, 2/3 period bytes, 4 overflow clear |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Read address: 0/1 count bytes, 2/3 period bytes |
| rd_data | output | 8 | Read data byte (combinational) |
| count | output | 16 | Current counter value |
| ovf | output | 1 | Sticky overflow flag |
| cmp_hit | output | 1 | Count equals period in special-event mode |

## Verification
Writes, internal-clock advances, special-event clears and overflow updates all show up one clock edge after the cycle that causes them. The bench drives inputs on the falling edge and reads results at the next falling edge. The reads and `cmp_hit` are combinational from registers, so they are checked in the same half-cycle as the state they reflect. A synchronized external edge needs three rising clock edges. The bench samples after the first and second edges, to confirm no early advance, and after the third. A bypassed edge is checked after the first edge. Table vectors keep `en` high for exactly N clock edges, so each expected count follows from N alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W  = 8;
    localparam int NBYTE   = 2;
    localparam int CNT_W   = BYTE_W * NBYTE;
    localparam int ADDR_W  = 3;
    localparam int SYNC_STAGES = 2;

    localparam logic [3:0] MODE_SEV = 4'b1011;
    localparam logic [ADDR_W-1:0] ADDR_OVF_CLR = ADDR_W'(2 * NBYTE);

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic [NBYTE-1:0] cnt_we;
        logic [NBYTE-1:0] per_we;
        logic             ovf_clr;
    } wr_dec_t;

    function automatic wr_dec_t decode_wr(input logic en, input logic [ADDR_W-1:0] a);
        wr_dec_t d;
        d = '0;
        if (en) begin
            for (int i = 0; i < NBYTE; i++) begin
                if (a == ADDR_W'(i))         d.cnt_we[i] = 1'b1;
                if (a == ADDR_W'(NBYTE + i)) d.per_we[i] = 1'b1;
            end
            d.ovf_clr = (a == ADDR_OVF_CLR);
        end
        return d;
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic src_ext,
    input  logic nosync,
    input  logic ext_clk,
    output logic tick,
    output logic async_mode
);
    logic [STAGES:0] sync_q;
    logic            raw_prev;
    logic            sync_edge;
    logic            raw_edge;
    logic            ext_edge;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= ext_clk;
    end

    for (genvar s = 1; s <= STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[s] <= 1'b0;
            else     sync_q[s] <= sync_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) raw_prev <= 1'b0;
        else     raw_prev <= ext_clk;
    end

    assign sync_edge  = sync_q[STAGES-1] & ~sync_q[STAGES];
    assign raw_edge   = ext_clk & ~raw_prev;
    assign ext_edge   = nosync ? raw_edge : sync_edge;
    assign tick       = en & (src_ext ? ext_edge : 1'b1);
    assign async_mode = src_ext & nosync;
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
    import tmr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_dec_t dec,
    input  byte_t   wr_data,
    input  logic [3:0] mode,
    input  cnt_t    count,
    input  logic    blocked,
    output cnt_t    period,
    output logic    hit,
    output logic    sev_fire
);
    for (genvar g = 0; g < NBYTE; g++) begin : g_per
        always_ff @(posedge clk) begin
            if (rst)
                period[g*BYTE_W +: BYTE_W] <= '1;
            else if (dec.per_we[g])
                period[g*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    assign hit      = (mode == MODE_SEV) && (count == period);
    assign sev_fire = hit & ~blocked;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    sev_fire,
    input  wr_dec_t dec,
    input  byte_t   wr_data,
    output cnt_t    count,
    output logic    ovf
);
    cnt_t written;
    cnt_t cnt_nxt;
    logic any_wr;
    logic ovf_set;

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        assign written[g*BYTE_W +: BYTE_W] =
            dec.cnt_we[g] ? wr_data : count[g*BYTE_W +: BYTE_W];
    end

    assign any_wr = |dec.cnt_we;

    always_comb begin
        cnt_nxt = count;
        ovf_set = 1'b0;
        if (any_wr) begin
            cnt_nxt = written;
        end else if (tick) begin
            if (sev_fire) begin
                cnt_nxt = '0;
            end else begin
                cnt_nxt = count + 1'b1;
                ovf_set = (count == '1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            count <= cnt_nxt;
            ovf   <= ovf_set | (ovf & ~dec.ovf_clr);
        end
    end
endmodule

// File: rtl/period_timer.sv
module period_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              src_ext,
    input  logic              nosync,
    input  logic [3:0]        mode,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              cmp_hit
);
    wr_dec_t dec;
    cnt_t    per_w;
    cnt_t    cnt_w;
    logic    tick;
    logic    async_mode;
    logic    sev_fire;

    assign dec = decode_wr(wr_en, wr_addr);

    tmr_tick_gen #(.STAGES(SYNC_STAGES)) u_tick (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .src_ext    (src_ext),
        .nosync     (nosync),
        .ext_clk    (ext_clk),
        .tick       (tick),
        .async_mode (async_mode)
    );

    tmr_compare u_cmp (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .wr_data  (wr_data),
        .mode     (mode),
        .count    (cnt_w),
        .blocked  (async_mode),
        .period   (per_w),
        .hit      (cmp_hit),
        .sev_fire (sev_fire)
    );

    tmr_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .sev_fire (sev_fire),
        .dec      (dec),
        .wr_data  (wr_data),
        .count    (cnt_w),
        .ovf      (ovf)
    );

    assign count = cnt_w;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NBYTE; i++) begin
            if (rd_addr == ADDR_W'(i))
                rd_data = cnt_w[i*BYTE_W +: BYTE_W];
            if (rd_addr == ADDR_W'(NBYTE + i))
                rd_data = per_w[i*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              src_ext,
    input logic              nosync,
    input logic [3:0]        mode,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  period,
    input logic              ovf
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (wr_addr < ADDR_W'(NBYTE));

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !ovf && period == '1));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_wr) |=> $stable(count));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf && !(wr_en && wr_addr == ADDR_OVF_CLR)) |=> ovf);

    p_wr_low_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd0) |=>
            (count[7:0] == $past(wr_data) && count[15:8] == $past(count[15:8])));

    p_sev_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !src_ext && mode == MODE_SEV && count == period && !cnt_wr)
            |=> count == '0);

    p_wr_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd1) |=> count[15:8] == $past(wr_data));

    p_no_ovf_r7: assert property (@(posedge clk) disable iff (rst)
        (!ovf && mode == MODE_SEV && count == period && !(src_ext && nosync))
            |=> !ovf);

    p_async_no_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (src_ext && nosync && mode == MODE_SEV && count == period &&
         count != '1 && !cnt_wr) |=> count != '0);
endmodule

bind period_timer period_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .src_ext (src_ext),
    .nosync  (nosync),
    .mode    (mode),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .count   (count),
    .period  (per_w),
    .ovf     (ovf)
);

// File: tb/period_timer_test.sv
`timescale 1ns/1ps
module period_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, src_ext = 1'b0, nosync = 1'b0, ext_clk = 1'b0;
    logic [3:0] mode = 4'd0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0, rd_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic [15:0] count;
    logic       ovf, cmp_hit;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    period_timer uut (
        .clk(clk), .rst(rst), .en(en), .src_ext(src_ext), .nosync(nosync),
        .mode(mode), .ext_clk(ext_clk), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .count(count), .ovf(ovf), .cmp_hit(cmp_hit)
    );

    typedef struct packed {
        logic [15:0] start;
        logic [15:0] per;
        logic        sev;
        logic [7:0]  n;
        logic [15:0] exp_cnt;
        logic        exp_ovf;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{16'h0000, 16'h0010, 1'b0, 8'd5, 16'h0005, 1'b0},
        '{16'h000E, 16'h0010, 1'b1, 8'd5, 16'h0002, 1'b0},
        '{16'hFFFE, 16'h0010, 1'b0, 8'd3, 16'h0001, 1'b1},
        '{16'hFFFE, 16'hFFFF, 1'b1, 8'd3, 16'h0001, 1'b0},
        '{16'h0010, 16'h0010, 1'b1, 8'd1, 16'h0000, 1'b0},
        '{16'h0011, 16'h0010, 1'b1, 8'd3, 16'h0014, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic load16(input logic [2:0] base, input logic [15:0] v);
        wr(base, v[7:0]);
        wr(base + 3'd1, v[15:8]);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 count", count, 16'h0000);
        chk("R1 ovf", {15'd0, ovf}, 16'd0);
        chk("R1 cmp_hit", {15'd0, cmp_hit}, 16'd0);
        rd_addr = 3'd2; #0.5;
        chk("R1 period lo", {8'd0, rd_data}, 16'h00FF);
        rd_addr = 3'd3; #0.5;
        chk("R1 period hi", {8'd0, rd_data}, 16'h00FF);

        // table walk: R2 R3 R5 R7
        for (int v = 0; v < 6; v++) begin
            en = 1'b0; mode = 4'd0;
            wr(3'd4, 8'h00);
            load16(3'd0, VECS[v].start);
            load16(3'd2, VECS[v].per);
            mode = VECS[v].sev ? 4'b1011 : 4'b0000;
            en = 1'b1;
            repeat (VECS[v].n) @(posedge clk);
            @(negedge clk);
            en = 1'b0;
            chk($sformatf("R2/R5 vec%0d count", v), count, VECS[v].exp_cnt);
            chk($sformatf("R3/R7 vec%0d ovf", v), {15'd0, ovf}, {15'd0, VECS[v].exp_ovf});
        end

        // R2 hold with enable low
        mode = 4'd0;
        load16(3'd0, 16'h1234);
        step(4);
        chk("R2 hold", count, 16'h1234);

        // R4 single byte write and reads
        wr(3'd0, 8'hAB);
        chk("R4 low byte write", count, 16'h12AB);
        rd_addr = 3'd0; #0.5;
        chk("R4 read lo", {8'd0, rd_data}, 16'h00AB);
        rd_addr = 3'd1; #0.5;
        chk("R4 read hi", {8'd0, rd_data}, 16'h0012);

        // R4 no advance in write cycle
        en = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h00;
        step(1);
        wr_en = 1'b0;
        chk("R4 no advance on write", count, 16'h1200);
        step(1);
        chk("R2 advance after write", count, 16'h1201);
        en = 1'b0;

        // R6 write beats special-event clear, R9 hit flag
        load16(3'd2, 16'h0050);
        load16(3'd0, 16'h0050);
        mode = 4'b1011; #0.5;
        chk("R9 hit at period", {15'd0, cmp_hit}, 16'd1);
        en = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h77;
        step(1);
        wr_en = 1'b0; en = 1'b0;
        chk("R6 write wins", count, 16'h0077);

        // R3 sticky, set beats clear, clear
        mode = 4'd0;
        wr(3'd4, 8'h00);
        load16(3'd0, 16'hFFFF);
        en = 1'b1; step(1); en = 1'b0;
        chk("R3 ovf set", {15'd0, ovf}, 16'd1);
        step(3);
        chk("R3 ovf sticky", {15'd0, ovf}, 16'd1);
        load16(3'd0, 16'hFFFF);
        wr(3'd4, 8'h00);
        chk("R3 cleared", {15'd0, ovf}, 16'd0);
        load16(3'd0, 16'hFFFF);
        en = 1'b1; wr_en = 1'b1; wr_addr = 3'd4;
        step(1);
        en = 1'b0; wr_en = 1'b0;
        chk("R3 set beats clear", {15'd0, ovf}, 16'd1);
        chk("R3 wrap value", count, 16'h0000);

        // R8 R9 R11 unsynchronized external clock
        src_ext = 1'b1; nosync = 1'b1; mode = 4'b1011;
        load16(3'd2, 16'h0005);
        load16(3'd0, 16'h0005);
        #0.5;
        chk("R9 hit in async mode", {15'd0, cmp_hit}, 16'd1);
        en = 1'b1; step(2);
        chk("R11 no edge no advance", count, 16'h0005);
        ext_clk = 1'b1;
        step(1);
        chk("R8/R11 advance past period at first edge", count, 16'h0006);
        step(2);
        chk("R11 once per rise", count, 16'h0006);
        ext_clk = 1'b0; step(1);

        // R10 synchronized external clock
        nosync = 1'b0; mode = 4'd0;
        load16(3'd0, 16'h0100);
        step(3);
        ext_clk = 1'b1;
        step(1);
        chk("R10 edge1", count, 16'h0100);
        step(1);
        chk("R10 edge2", count, 16'h0100);
        step(1);
        chk("R10 edge3", count, 16'h0101);
        step(3);
        chk("R10 once per rise", count, 16'h0101);

        // R5 clear in synchronized counter mode
        ext_clk = 1'b0;
        load16(3'd2, 16'h0101);
        mode = 4'b1011;
        step(3);
        ext_clk = 1'b1;
        step(3);
        chk("R5 sync clear", count, 16'h0000);
        ext_clk = 1'b0; en = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule